// File: doc/BRIEF.md
# Seeded Jump PRBS Sequencer

This block hands out a stream of pseudo-random 8-bit indices. It is meant for shuffled playback order or for driving test stimulus. A plain narrow LFSR always follows a value with the same successor, which makes the order easy to predict. This block avoids that in two ways. First, it takes its seed from a human event: a counter runs from reset release until the first keypress strobe, and the count it has reached on that cycle is loaded into a 16-bit Fibonacci LFSR. Second, every advance request moves the register forward by a caller-chosen number of shifts rather than by one.

The index is only the low byte of the 16-bit register. The same index can therefore appear twice in a row, and any ordered pair of values is possible. A captured seed of zero is replaced by the constant 16'hACE1. This keeps the register out of the all-zero lock-up state.

A controller with three states sequences the block:

- **AWAIT_KEY** (after reset): the seed timer runs.
  - AWAIT_KEY → READY happens on the keypress, and loads the seed.
- **READY**: the block waits for an advance request.
  - READY → STEPPING happens on a next request, and latches the jump count.
- **STEPPING**: the register makes one shift per clock.
  - STEPPING → READY happens after the last shift, and raises valid for one cycle.

Top module: `prbs_jump_seq`

## Requirements
- R1: While reset is asserted and right after it, `valid_o` is 0, and `idx_o` shows the low byte of 16'hACE1, which is 8'hE1.
- R2: Before the first keypress, `next_i` is ignored and `valid_o` stays 0.
- R3: Let K be the number of rising clock edges after reset release during which `key_i` was low. On the edge that samples the first `key_i` high, the register loads K. One cycle later `valid_o` is 1 for exactly one cycle and `idx_o` equals K[7:0].
- R4: If the captured count is zero, meaning the key was already high on the first edge after reset release, the register loads 16'hACE1 instead.
- R5: One shift maps state s to {s[14:0], s[15]^s[14]^s[12]^s[3]}. These are taps 16, 15, 13 and 4, and the register never holds zero.
- R6: A `next_i` sampled high in READY with `jump_i`=N≥1 performs exactly N shifts, one per clock. `valid_o` goes high for one cycle on the Nth edge after the request edge. From the request, this is N+1 negedge samples later.
- R7: A `jump_i` of 0 is treated as one shift.
- R8: A `next_i` that arrives while STEPPING is ignored. It neither restarts nor extends the jump.
- R9: `idx_o` is bits [7:0] of the register. A keypress after the first one changes neither the register nor `valid_o`.
- R10: `valid_o` is 0 for the whole time the block is STEPPING.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_i | input | 1 | User keypress strobe; the first one seeds the generator |
| next_i | input | 1 | Advance request, sampled in READY |
| jump_i | input | 8 | Number of shifts per advance (0 means 1) |
| idx_o | output | 8 | Current index, the low byte of the register |
| valid_o | output | 1 | One-cycle pulse when a new index is ready |

## Verification
The bench builds the block with its default parameters: a 16-bit register, an 8-bit index and an 8-bit jump field. With these values a jump of 255 shifts, the largest the field can carry, fits within a short run. It exercises the 255-shift jump, a zero jump, and the zero-seed fallback. A behavioural model of the seed count, the shift rule and the request handling is compared against `valid_o` and `idx_o` on every clock. Further checks cover the latency of each jump, a request arriving mid-jump, and a second keypress.

// File: rtl/prbs_seq_pkg.sv
`timescale 1ns/1ps
package prbs_seq_pkg;
    typedef enum logic [1:0] {
        ST_AWAIT_KEY = 2'd0,
        ST_READY     = 2'd1,
        ST_STEPPING  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/prbs_seed_timer.sv
`timescale 1ns/1ps
module prbs_seed_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (run_i && count_q != CNT_MAX) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count_o = count_q;

    // R3: the seed count freezes once the timer is no longer running
    // R3
    count_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> $stable(count_q));
endmodule

// File: rtl/prbs_lfsr.sv
`timescale 1ns/1ps
module prbs_lfsr #(
    parameter int              W        = 16,
    parameter logic [W-1:0]    TAP_MASK = 16'hD008,
    parameter logic [W-1:0]    FALLBACK = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] seed_i,
    input  logic         step_i,
    output logic [W-1:0] state_o
);
    logic [W-1:0] state_q;
    logic [W-1:0] tapped;
    logic         fb;

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_tap
            if (TAP_MASK[gi]) begin : g_on
                assign tapped[gi] = state_q[gi];
            end else begin : g_off
                assign tapped[gi] = 1'b0;
            end
        end
    endgenerate

    assign fb = ^tapped;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FALLBACK;
        end else if (load_i) begin
            state_q <= (seed_i == '0) ? FALLBACK : seed_i;
        end else if (step_i) begin
            state_q <= {state_q[W-2:0], fb};
        end
    end

    assign state_o = state_q;

    // R5
    never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

    // R4
    zero_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && seed_i == '0) |=> state_q == FALLBACK);
endmodule

// File: rtl/prbs_ctrl.sv
`timescale 1ns/1ps
module prbs_ctrl
    import prbs_seq_pkg::*;
#(
    parameter int JUMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_i,
    input  logic              next_i,
    input  logic [JUMP_W-1:0] jump_i,
    output logic              count_en_o,
    output logic              load_o,
    output logic              step_o,
    output logic              valid_o
);
    localparam logic [JUMP_W-1:0] ONE = JUMP_W'(1);

    seq_state_e        state_q, state_d;
    logic [JUMP_W-1:0] rem_q, rem_d;
    logic              valid_q, valid_d;

    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        valid_d = 1'b0;
        unique case (state_q)
            ST_AWAIT_KEY: begin
                if (key_i) begin
                    state_d = ST_READY;
                    valid_d = 1'b1;
                end
            end
            ST_READY: begin
                if (next_i) begin
                    state_d = ST_STEPPING;
                    rem_d   = (jump_i == '0) ? ONE : jump_i;
                end
            end
            ST_STEPPING: begin
                rem_d = rem_q - 1'b1;
                if (rem_q == ONE) begin
                    state_d = ST_READY;
                    valid_d = 1'b1;
                end
            end
            default: state_d = ST_AWAIT_KEY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_AWAIT_KEY;
            rem_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
            valid_q <= valid_d;
        end
    end

    always_comb begin
        count_en_o = (state_q == ST_AWAIT_KEY);
        load_o     = (state_q == ST_AWAIT_KEY) && key_i;
        step_o     = (state_q == ST_STEPPING);
        valid_o    = valid_q;
    end

    // R10
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_STEPPING |-> !valid_q);

    // R2
    unseeded_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_AWAIT_KEY |-> !valid_q);

    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);

    // R8
    countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEPPING && rem_q > ONE) |=>
        (state_q == ST_STEPPING && rem_q == $past(rem_q - 1'b1)));

    // R9
    seeded_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != ST_AWAIT_KEY |=> state_q != ST_AWAIT_KEY);
endmodule

// File: rtl/prbs_jump_seq.sv
`timescale 1ns/1ps
module prbs_jump_seq #(
    parameter int                 LFSR_W   = 16,
    parameter int                 IDX_W    = 8,
    parameter int                 JUMP_W   = 8,
    parameter logic [LFSR_W-1:0]  TAP_MASK = 16'hD008,
    parameter logic [LFSR_W-1:0]  FALLBACK = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_i,
    input  logic              next_i,
    input  logic [JUMP_W-1:0] jump_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic              valid_o
);
    localparam int CNT_W = LFSR_W;

    logic              count_en;
    logic              load;
    logic              step;
    logic [CNT_W-1:0]  seed_count;
    logic [LFSR_W-1:0] lfsr_state;

    prbs_ctrl #(.JUMP_W(JUMP_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_i      (key_i),
        .next_i     (next_i),
        .jump_i     (jump_i),
        .count_en_o (count_en),
        .load_o     (load),
        .step_o     (step),
        .valid_o    (valid_o)
    );

    prbs_seed_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (count_en),
        .count_o (seed_count)
    );

    prbs_lfsr #(.W(LFSR_W), .TAP_MASK(TAP_MASK), .FALLBACK(FALLBACK)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .seed_i  (seed_count),
        .step_i  (step),
        .state_o (lfsr_state)
    );

    assign idx_o = lfsr_state[IDX_W-1:0];

    // R9
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(idx_o));
endmodule

// File: tb/sim_prbs_jump_seq.sv
`timescale 1ns/1ps
module sim_prbs_jump_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       key = 1'b0;
    logic       nxt = 1'b0;
    logic [7:0] jmp = 8'd0;
    logic [7:0] idx_o;
    logic       valid_o;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #5 clk = ~clk;

    prbs_jump_seq u0 (
        .clk(clk), .rst_n(rst_n), .key_i(key), .next_i(nxt),
        .jump_i(jmp), .idx_o(idx_o), .valid_o(valid_o)
    );

    function automatic logic [15:0] shift1(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: 0 unseeded, 1 ready, 2 stepping
    int          m_phase;
    int          m_cnt;
    int          m_left;
    logic [15:0] m_lfsr;
    bit          m_valid;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_left = 0; m_lfsr = 16'hACE1; m_valid = 0;
        end else begin
            m_valid = 0;
            if (m_phase == 0) begin
                if (key) begin
                    m_lfsr  = (m_cnt == 0) ? 16'hACE1 : 16'(m_cnt);
                    m_phase = 1;
                    m_valid = 1;
                end else if (m_cnt < 65535) begin
                    m_cnt++;
                end
            end else if (m_phase == 1) begin
                if (nxt) begin
                    m_left  = (jmp == 0) ? 1 : int'(jmp);
                    m_phase = 2;
                end
            end else begin
                m_lfsr = shift1(m_lfsr);
                m_left--;
                if (m_left == 0) begin
                    m_phase = 1;
                    m_valid = 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(valid_o === m_valid && idx_o === m_lfsr[7:0],
                (m_phase == 0) ? "R2" : (m_phase == 2) ? "R10" : "R5",
                {valid_o, idx_o}, {m_valid, m_lfsr[7:0]});
        end
    end

    task automatic advance(input logic [7:0] j, input string tag);
        int lat;
        int want;
        nxt = 1'b1; jmp = j;
        @(negedge clk);
        nxt = 1'b0;
        lat = 1;
        while (!valid_o && lat < 400) begin
            @(negedge clk);
            lat++;
        end
        want = ((j == 0) ? 1 : int'(j)) + 1;
        chk(lat == want, tag, lat, want);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1
        chk(valid_o === 1'b0 && idx_o === 8'hE1, "R1", {valid_o, idx_o}, 9'h0E1);
        rst_n = 1'b1;
        // R2: requests before the key are ignored
        nxt = 1'b1; jmp = 8'd3;
        repeat (10) @(negedge clk);
        nxt = 1'b0;
        chk(valid_o === 1'b0, "R2", valid_o, 0);
        repeat (27) @(negedge clk);
        // R3: 37 edges counted, seed loads on the 38th
        key = 1'b1;
        @(negedge clk);
        key = 1'b0;
        chk(valid_o === 1'b1 && idx_o === 8'd37, "R3", {valid_o, idx_o}, {1'b1, 8'd37});
        @(negedge clk);
        chk(valid_o === 1'b0, "R3", valid_o, 0);
        // R6 / R7 latencies
        advance(8'd1,   "R6");
        advance(8'd5,   "R6");
        advance(8'd0,   "R7");
        advance(8'd255, "R6");
        advance(8'd17,  "R6");
        // R8: second request mid-jump is ignored
        begin
            int pulses;
            pulses = 0;
            nxt = 1'b1; jmp = 8'd20;
            @(negedge clk);
            nxt = 1'b0;
            repeat (4) @(negedge clk);
            nxt = 1'b1; jmp = 8'd2;
            @(negedge clk);
            nxt = 1'b0;
            for (int i = 0; i < 40; i++) begin
                if (valid_o) pulses++;
                @(negedge clk);
            end
            chk(pulses == 1, "R8", pulses, 1);
        end
        // R9: later keypress has no effect
        begin
            logic [7:0] held;
            held = idx_o;
            key = 1'b1;
            @(negedge clk);
            key = 1'b0;
            chk(valid_o === 1'b0 && idx_o === held, "R9", {valid_o, idx_o}, {1'b0, held});
        end
        // back-to-back requests held high
        nxt = 1'b1; jmp = 8'd1;
        repeat (12) @(negedge clk);
        nxt = 1'b0;
        repeat (3) @(negedge clk);
        // R4: key high on the first edge gives a zero count
        rst_n = 1'b0;
        key = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        key = 1'b0;
        chk(valid_o === 1'b1 && idx_o === 8'hE1, "R4", {valid_o, idx_o}, {1'b1, 8'hE1});
        advance(8'd1, "R5");
        chk(idx_o === 8'hC3, "R5", idx_o, 8'hC3);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule